// File: doc/BRIEF.md
# Multi-Format Packet Timing Generator

This block times the transmit gating of one packet on a low-rate carrier link. A packet is four back-to-back segments: a control segment, a start-marker segment, an end-marker segment and a trailer segment. Each segment lasts a whole number of 25 us units. A free-running unit tick, one clock wide, marks the units. The length of the control segment depends on a 2-bit format code. The other three segments have fixed lengths.

A start request launches a packet while the block is idle. The format code is taken at that moment and kept until the packet ends. While the packet runs, the block reports which segment is active, strobes every unit it uses, and pulses done once when the trailer's last unit has been used. The analog carrier and its antenna are driven elsewhere, gated by busy and the segment code.

Top module: `pkt_sched`

## Requirements
- R1: After reset and while idle, busy, done and unit_stb are low, even when unit_tick is high.
- R2: While busy, the segment code steps only upward, in the order 0 (control), 1 (start marker), 2 (end marker), 3 (trailer). Each step is one increment.
- R3: The control segment uses 60, 90, 120 or 140 units for format codes 0, 1, 2 and 3.
- R4: The start-marker segment and the end-marker segment each use 40 units.
- R5: The trailer segment uses 120 units.
- R6: The format code is taken when a start is accepted. Changes to it during a packet have no effect on that packet.
- R7: A start request while busy is ignored. The packet in flight keeps its segment lengths and gives a single done.
- R8: done is high for exactly one cycle. That cycle directly follows the cycle in which the trailer's last unit is used, and busy is low in it.
- R9: unit_stb is high exactly in the cycles where busy and unit_tick are both high. The number of strobes in a packet equals the sum of the four segment lengths (260, 290, 320 or 340).
- R10: While busy with unit_tick low, the segment code and busy hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| unit_tick | input | 1 | One-cycle pulse per 25 us unit |
| start | input | 1 | Packet launch request |
| fmt_sel | input | 2 | Format code for the control segment length |
| busy | output | 1 | Packet in progress |
| session | output | 2 | Active segment code, valid while busy |
| unit_stb | output | 1 | A unit is used in this cycle |
| done | output | 1 | One-cycle end-of-packet pulse |

## Verification
A wrong unit count or wrong length lookup moves the segment boundaries. It shows in the per-segment strobe counts as soon as the first wrong segment ends, which can be after up to 140 units. A wrong segment register shows as a skipped or repeated code at the next boundary. A wrong end decision shows as a missing, doubled or misplaced done in the cycle after the trailer's last strobe. A start wrongly accepted mid-packet restarts the control segment, and both the strobe counts and the done count catch it.

// File: rtl/pkt_sched_pkg.sv
package pkt_sched_pkg;
   typedef enum logic [1:0] {
      SEG_CTRL  = 2'd0,
      SEG_SMARK = 2'd1,
      SEG_EMARK = 2'd2,
      SEG_TRAIL = 2'd3
   } seg_e;
endpackage

// File: rtl/pkt_seg_len.sv
module pkt_seg_len #(
   parameter int CTRL_LEN0 = 60,
   parameter int CTRL_LEN1 = 90,
   parameter int CTRL_LEN2 = 120,
   parameter int CTRL_LEN3 = 140,
   parameter int SMARK_LEN = 40,
   parameter int EMARK_LEN = 40,
   parameter int TRAIL_LEN = 120,
   parameter int CW        = 8
) (
   input  logic [1:0]    fmt,
   input  logic [1:0]    seg,
   output logic [CW-1:0] len
);
   import pkt_sched_pkg::*;

   logic [CW-1:0] ctrl_len;

   always_comb begin
      case (fmt)
         2'd0:    ctrl_len = CW'(CTRL_LEN0);
         2'd1:    ctrl_len = CW'(CTRL_LEN1);
         2'd2:    ctrl_len = CW'(CTRL_LEN2);
         default: ctrl_len = CW'(CTRL_LEN3);
      endcase
   end

   always_comb begin
      case (seg_e'(seg))
         SEG_CTRL:  len = ctrl_len;
         SEG_SMARK: len = CW'(SMARK_LEN);
         SEG_EMARK: len = CW'(EMARK_LEN);
         default:   len = CW'(TRAIL_LEN);
      endcase
   end
endmodule

// File: rtl/pkt_unit_ctr.sv
module pkt_unit_ctr #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  logic [CW-1:0] limit,
   output logic          last
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else if (step)  cnt_q <= cnt_q + CW'(1);
   end

   assign last = (cnt_q == limit - CW'(1));
endmodule

// File: rtl/pkt_sched.sv
module pkt_sched #(
   parameter int CTRL_LEN0 = 60,
   parameter int CTRL_LEN1 = 90,
   parameter int CTRL_LEN2 = 120,
   parameter int CTRL_LEN3 = 140,
   parameter int SMARK_LEN = 40,
   parameter int EMARK_LEN = 40,
   parameter int TRAIL_LEN = 120
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       unit_tick,
   input  logic       start,
   input  logic [1:0] fmt_sel,
   output logic       busy,
   output logic [1:0] session,
   output logic       unit_stb,
   output logic       done
);
   import pkt_sched_pkg::*;

   localparam int MAX_CTRL = (CTRL_LEN0 > CTRL_LEN1 ? CTRL_LEN0 : CTRL_LEN1) >
                             (CTRL_LEN2 > CTRL_LEN3 ? CTRL_LEN2 : CTRL_LEN3) ?
                             (CTRL_LEN0 > CTRL_LEN1 ? CTRL_LEN0 : CTRL_LEN1) :
                             (CTRL_LEN2 > CTRL_LEN3 ? CTRL_LEN2 : CTRL_LEN3);
   localparam int MAX_FIX  = (SMARK_LEN > EMARK_LEN ? SMARK_LEN : EMARK_LEN) > TRAIL_LEN ?
                             (SMARK_LEN > EMARK_LEN ? SMARK_LEN : EMARK_LEN) : TRAIL_LEN;
   localparam int MAX_LEN  = MAX_CTRL > MAX_FIX ? MAX_CTRL : MAX_FIX;
   localparam int CW       = $clog2(MAX_LEN + 1);

   if (CTRL_LEN0 < 1 || CTRL_LEN1 < 1 || CTRL_LEN2 < 1 || CTRL_LEN3 < 1) begin : g_bad_ctrl
      $error("pkt_sched: every control segment length must be at least one unit");
   end
   if (SMARK_LEN < 1 || EMARK_LEN < 1 || TRAIL_LEN < 1) begin : g_bad_fix
      $error("pkt_sched: fixed segment lengths must be at least one unit");
   end

   logic          busy_q, done_q;
   logic [1:0]    seg_q, fmt_q;
   logic [CW-1:0] cur_len;
   logic          ctr_last, start_acc, step, seg_end, pkt_end;

   assign start_acc = start & ~busy_q;
   assign step      = busy_q & unit_tick;
   assign seg_end   = step & ctr_last;
   assign pkt_end   = seg_end & (seg_e'(seg_q) == SEG_TRAIL);

   pkt_seg_len #(
      .CTRL_LEN0(CTRL_LEN0), .CTRL_LEN1(CTRL_LEN1),
      .CTRL_LEN2(CTRL_LEN2), .CTRL_LEN3(CTRL_LEN3),
      .SMARK_LEN(SMARK_LEN), .EMARK_LEN(EMARK_LEN),
      .TRAIL_LEN(TRAIL_LEN), .CW(CW)
   ) u_len (
      .fmt (fmt_q),
      .seg (seg_q),
      .len (cur_len)
   );

   pkt_unit_ctr #(.CW(CW)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start_acc | seg_end),
      .step  (step),
      .limit (cur_len),
      .last  (ctr_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         seg_q  <= SEG_CTRL;
         fmt_q  <= 2'd0;
      end else begin
         done_q <= pkt_end;
         if (start_acc) begin
            busy_q <= 1'b1;
            seg_q  <= SEG_CTRL;
            fmt_q  <= fmt_sel;
         end else if (pkt_end) begin
            busy_q <= 1'b0;
            seg_q  <= SEG_CTRL;
         end else if (seg_end) begin
            seg_q  <= seg_q + 2'd1;
         end
      end
   end

   assign busy     = busy_q;
   assign session  = seg_q;
   assign unit_stb = step;
   assign done     = done_q;
endmodule

// File: rtl/pkt_sched_chk.sv
module pkt_sched_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       unit_tick,
   input logic       start,
   input logic       busy,
   input logic [1:0] session,
   input logic       unit_stb,
   input logic       done
);
   // R8
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R10
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !unit_tick) |=> (busy && $stable(session)));

   // R2
   seg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && session != $past(session)) |->
         (session == 2'($past(session) + 2'd1)));

   // R7
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !unit_tick) |=> (busy && $stable(session)));

   // R9
   stb_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unit_stb |-> busy);
endmodule

bind pkt_sched pkt_sched_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .unit_tick (unit_tick),
   .start     (start),
   .busy      (busy),
   .session   (session),
   .unit_stb  (unit_stb),
   .done      (done)
);

// File: tb/test_pkt_sched.sv
`timescale 1ns/1ps
module test_pkt_sched;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       unit_tick = 1'b0;
   logic       start = 1'b0;
   logic [1:0] fmt_sel = 2'd0;
   logic       busy, unit_stb, done;
   logic [1:0] session;

   int checks = 0;
   int errors = 0;
   int cyc_all = 0;

   always #2.5 clk = ~clk;

   pkt_sched i_pkt_sched (
      .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick), .start(start),
      .fmt_sel(fmt_sel), .busy(busy), .session(session),
      .unit_stb(unit_stb), .done(done)
   );

   // vector table: format, tick gap in cycles, expected control length, mid-packet disturbance
   localparam int NV = 6;
   localparam int V_FMT [NV] = '{0, 1, 2, 3, 1, 3};
   localparam int V_GAP [NV] = '{1, 3, 1, 2, 1, 3};
   localparam int V_LEN [NV] = '{60, 90, 120, 140, 90, 140};
   localparam int V_MID [NV] = '{0, 0, 0, 0, 1, 1};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc_all++;
      if (cyc_all > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc_all, 100000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic run_pkt(input int fmt, input int gap, input int exp_ctrl, input int mid);
      int seg_cnt [4];
      int stb_total, stb_bad, done_cnt, done_cyc, last_stb, order_bad, prev_seg, busy_at_done;
      int after;
      for (int k = 0; k < 4; k++) seg_cnt[k] = 0;
      stb_total = 0; stb_bad = 0; done_cnt = 0; done_cyc = -1; last_stb = -1;
      order_bad = 0; prev_seg = 0; busy_at_done = 0; after = 0;
      @(negedge clk);
      fmt_sel = 2'(fmt);
      start = 1'b1;
      unit_tick = 1'b0;
      for (int cyc = 0; cyc < 4000; cyc++) begin
         @(negedge clk);
         start = 1'b0;
         unit_tick = ((cyc % gap) == 0);
         if (mid != 0 && cyc == 30) begin
            start = 1'b1;
            fmt_sel = 2'(~fmt);
         end
         #1;
         if (unit_stb) begin
            seg_cnt[session]++;
            stb_total++;
            last_stb = cyc;
            if (!unit_tick || !busy) stb_bad++;
         end else if (busy && unit_tick) stb_bad++;
         if (busy) begin
            if (int'(session) < prev_seg || int'(session) > prev_seg + 1) order_bad++;
            prev_seg = int'(session);
         end
         if (done) begin
            done_cnt++;
            if (done_cyc < 0) done_cyc = cyc;
            if (busy) busy_at_done++;
         end
         if (done_cyc >= 0) begin
            after++;
            if (after > 3) break;
         end
      end
      unit_tick = 1'b0;
      chk(seg_cnt[0] == exp_ctrl, mid != 0 ? "R6 R7 control length" : "R3 control length",
          seg_cnt[0], exp_ctrl);
      chk(seg_cnt[1] == 40, "R4 start-marker length", seg_cnt[1], 40);
      chk(seg_cnt[2] == 40, "R4 end-marker length", seg_cnt[2], 40);
      chk(seg_cnt[3] == 120, "R5 trailer length", seg_cnt[3], 120);
      chk(stb_total == exp_ctrl + 200, "R9 strobe total", stb_total, exp_ctrl + 200);
      chk(stb_bad == 0, "R9 strobe only on busy tick", stb_bad, 0);
      chk(order_bad == 0, "R2 segment order", order_bad, 0);
      chk(done_cnt == 1, mid != 0 ? "R7 single done" : "R8 done width", done_cnt, 1);
      chk(done_cyc == last_stb + 1, "R8 done timing", done_cyc, last_stb + 1);
      chk(busy_at_done == 0, "R8 busy low with done", busy_at_done, 0);
   endtask

   initial begin
      // R1: reset state, tick high while idle
      unit_tick = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk(busy == 1'b0, "R1 busy after reset", busy, 0);
      chk(done == 1'b0, "R1 done after reset", done, 0);
      chk(unit_stb == 1'b0, "R1 strobe while idle", unit_stb, 0);
      unit_tick = 1'b0;

      for (int v = 0; v < NV; v++)
         run_pkt(V_FMT[v], V_GAP[v], V_LEN[v], V_MID[v]);

      // R10: no ticks, no progress
      @(negedge clk);
      fmt_sel = 2'd2;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      #1;
      chk(busy == 1'b1, "R10 busy held", busy, 1);
      chk(session == 2'd0, "R10 segment held", session, 0);
      chk(done == 1'b0, "R10 no done", done, 0);

      // R1: reset in mid-packet returns to idle
      rst_n = 1'b0;
      @(negedge clk);
      unit_tick = 1'b1;
      #1;
      chk(busy == 1'b0, "R1 busy after mid-packet reset", busy, 0);
      chk(unit_stb == 1'b0, "R1 strobe in reset", unit_stb, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(busy == 1'b0 && done == 1'b0, "R1 idle after release", busy, 0);
      unit_tick = 1'b0;

      // shortest control segment again after reset
      run_pkt(0, 2, 60, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule